// File: doc/BRIEF.md
# Opaque Stipple Pixel Expander

This block sits between a host write path and a frame-buffer memory port. It turns one-bit-per-pixel mask words into coloured pixel writes. It holds a foreground colour register, a background colour register, a per-pixel write-enable mask and a mode register.

In plain mode, a host data write passes to memory unchanged as one full word. In opaque stipple mode, one host data word stands for 32 consecutive pixels starting at the written address. A pixel whose data bit is 1 gets the foreground colour, and a pixel whose data bit is 0 gets the background colour. A pixel whose pixel-mask bit is 0 is not written at all.

Two depths are supported: 8-bit pixels (32 bytes per stipple word) and 32-bit pixels (128 bytes per stipple word). While an expansion runs, the block raises a stall output. The host must hold any pending register or data write until the stall drops.

Top module: `stipple_expander`

## Requirements
- R1: After reset, `busy`, `host_stall` and `mem_we` are low. The pixel mask is all ones and the mode is plain with 8-bit pixels.
- R2: In plain mode, an accepted data write produces exactly one memory write in the next cycle. That write has the word-aligned address, the unchanged data and all four byte enables set.
- R3: In stipple mode, data bit i controls the pixel at byte offset i×(bytes per pixel) from the base. Bit 0 is the leftmost pixel, at the lowest address. A 1 bit selects the foreground colour and a 0 bit selects the background colour.
- R4: At 8-bit depth, the byte written for a pixel is the colour register byte in the same lane as that pixel's address modulo 4. The expansion runs as 8 word beats, one byte enable per pixel.
- R5: At 32-bit depth, each pixel receives the full 32-bit colour. The expansion runs as 32 word beats with all byte enables set.
- R6: A pixel whose pixel-mask bit is 0 leaves memory unchanged. A beat with no enabled pixel issues no memory write.
- R7: In stipple mode, the two low address bits are ignored and the base is word aligned. Every memory write is word aligned.
- R8: After a stipple write is accepted, `busy` is high for exactly 8 cycles at 8-bit depth and exactly 32 cycles at 32-bit depth.
- R9: While `host_stall` is high, register and data writes are not accepted. A write held through the stall takes effect once the stall drops, so an expansion in flight uses the colours it started with.
- R10: `reg_sel` encodes 0 = foreground, 1 = background, 2 = pixel mask and 3 = mode. In the mode value, bit 0 set selects stipple mode and bit 1 set selects 32-bit pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write request |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write value |
| fb_we | input | 1 | Frame-buffer data write request |
| fb_addr | input | AW | Frame-buffer byte address |
| fb_wdata | input | 32 | Data word or stipple word |
| host_stall | output | 1 | Hold pending writes |
| busy | output | 1 | Expansion in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |

## Verification
The bench builds the block with a 12-bit address and the 32-bit word. This makes the whole 4096-byte frame buffer small enough to shadow in full. After every operation it compares every byte, so stray writes anywhere are caught, not only writes inside the target span. Both depths are swept over single-bit, dense, random and empty data and mask words, with all four low-address offsets. Beat counts and busy spans are also compared against values derived from the mask.

// File: rtl/stipple_pkg.sv
package stipple_pkg;
  typedef enum logic [1:0] {
    SEL_FG    = 2'd0,
    SEL_BG    = 2'd1,
    SEL_PMASK = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic deep;     // 1: 32-bit pixels, 0: 8-bit pixels
    logic stipple;  // 1: opaque stipple, 0: plain write-through
  } mode_t;
endpackage

// File: rtl/stip_regs.sv
module stip_regs
  import stipple_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] fg,
  output logic [DW-1:0] bg,
  output logic [DW-1:0] pmask,
  output mode_t         mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fg    <= '0;
      bg    <= '0;
      pmask <= '1;
      mode  <= '0;
    end else if (we) begin
      unique case (reg_sel_e'(sel))
        SEL_FG:    fg    <= wdata;
        SEL_BG:    bg    <= wdata;
        SEL_PMASK: pmask <= wdata;
        SEL_MODE:  mode  <= mode_t'(wdata[1:0]);
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/stip_lanes.sv
module stip_lanes #(
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic [LANES-1:0]    bits,
  input  logic [LANES-1:0]    en,
  input  logic [LANES*LW-1:0] fg,
  input  logic [LANES*LW-1:0] bg,
  output logic [LANES*LW-1:0] word,
  output logic [LANES-1:0]    be
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word[k*LW +: LW] = bits[k] ? fg[k*LW +: LW] : bg[k*LW +: LW];
    assign be[k]            = en[k];
  end
endmodule

// File: rtl/stip_engine.sv
module stip_engine #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pass,
  input  logic            start,
  input  logic            deep,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  input  logic [DW-1:0]   pmask,
  input  logic [DW-1:0]   fg,
  input  logic [DW-1:0]   bg,
  output logic            busy,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be
);
  localparam int LANES  = DW / 8;
  localparam int AL     = $clog2(LANES);
  localparam int PIX    = DW;
  localparam int BEATSN = PIX / LANES;
  localparam int BEATSW = PIX;
  localparam int CW     = $clog2(PIX + 1);

  logic [DW-1:0]    dat_q, msk_q;
  logic [CW-1:0]    left_q;
  logic [AW-1:0]    cur_q;
  logic             deep_q;
  logic             out_stip_q, out_deep_q;
  logic [LANES-1:0] l_bits, l_en, l_be;
  logic [DW-1:0]    l_word;
  logic [AW-1:0]    base;

  assign base   = {addr[AW-1:AL], {AL{1'b0}}};
  assign l_bits = deep_q ? {LANES{dat_q[0]}} : dat_q[LANES-1:0];
  assign l_en   = deep_q ? {LANES{msk_q[0]}} : msk_q[LANES-1:0];

  stip_lanes #(.LANES(LANES), .LW(8)) lanes_i (
    .bits(l_bits), .en(l_en), .fg(fg), .bg(bg), .word(l_word), .be(l_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      dat_q      <= '0;
      msk_q      <= '0;
      left_q     <= '0;
      cur_q      <= '0;
      deep_q     <= 1'b0;
      out_stip_q <= 1'b0;
      out_deep_q <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (pass) begin
        mem_we     <= 1'b1;
        mem_addr   <= base;
        mem_wdata  <= data;
        mem_be     <= '1;
        out_stip_q <= 1'b0;
      end else if (start) begin
        busy   <= 1'b1;
        dat_q  <= data;
        msk_q  <= pmask;
        cur_q  <= base;
        deep_q <= deep;
        left_q <= deep ? CW'(BEATSW - 1) : CW'(BEATSN - 1);
      end else if (busy) begin
        mem_we     <= |l_be;
        mem_addr   <= cur_q;
        mem_wdata  <= l_word;
        mem_be     <= l_be;
        out_stip_q <= 1'b1;
        out_deep_q <= deep_q;
        dat_q      <= deep_q ? (dat_q >> 1) : (dat_q >> LANES);
        msk_q      <= deep_q ? (msk_q >> 1) : (msk_q >> LANES);
        cur_q      <= cur_q + AW'(LANES);
        left_q     <= left_q - CW'(1);
        if (left_q == '0) busy <= 1'b0;
      end
    end
  end

  assert_addr_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AL-1:0] == '0));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  assert_deep_fullword_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && out_stip_q && out_deep_q) |-> (mem_be == '1));

  assert_plain_fullword_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !out_stip_q) |-> (mem_be == '1));
endmodule

// File: rtl/stipple_expander.sv
module stipple_expander
  import stipple_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            fb_we,
  input  logic [AW-1:0]   fb_addr,
  input  logic [DW-1:0]   fb_wdata,
  output logic            host_stall,
  output logic            busy,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be
);
  logic [DW-1:0] fg, bg, pmask;
  mode_t         mode;
  logic          reg_acc, fb_acc;

  assign host_stall = busy;
  assign reg_acc    = reg_we & ~busy;
  assign fb_acc     = fb_we & ~busy;

  stip_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_acc), .sel(reg_sel), .wdata(reg_wdata),
    .fg(fg), .bg(bg), .pmask(pmask), .mode(mode)
  );

  stip_engine #(.AW(AW), .DW(DW)) eng_i (
    .clk(clk), .rst(rst),
    .pass(fb_acc & ~mode.stipple), .start(fb_acc & mode.stipple),
    .deep(mode.deep), .addr(fb_addr), .data(fb_wdata),
    .pmask(pmask), .fg(fg), .bg(bg),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  assert_regs_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    $past(host_stall) |-> ($stable(fg) && $stable(bg) && $stable(pmask) && $stable(mode)));
endmodule

// File: tb/stipple_expander_tb.sv
module stipple_expander_tb_top;
  localparam int AW = 12;
  localparam int MB = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic fb_we = 1'b0;
  logic [AW-1:0] fb_addr = '0;
  logic [31:0] fb_wdata = '0;
  logic host_stall, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;

  always #2.5 clk = ~clk;

  stipple_expander #(.AW(AW), .DW(32)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .host_stall(host_stall), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  int checks = 0, fails = 0;
  logic [7:0] sh [MB];
  logic [7:0] ex [MB];
  int busy_cnt = 0, we_cnt = 0;
  logic stall_seen = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (mem_we) begin
      we_cnt++;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) sh[(int'(mem_addr) + b) % MB] = mem_wdata[8*b +: 8];
    end
    if (busy) busy_cnt++;
    if (host_stall && (fb_we || reg_we)) stall_seen = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic reg_write(logic [1:0] s, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    while (host_stall) @(negedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fb_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    fb_we = 1'b1; fb_addr = a; fb_wdata = d;
    while (host_stall) @(negedge clk);
    @(negedge clk);
    fb_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic void model(logic [AW-1:0] a, logic [31:0] d, logic [31:0] m,
                                bit deep, logic [31:0] f, logic [31:0] g);
    int base = int'(a) & ~3;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        logic [31:0] c = d[i] ? f : g;
        if (deep) for (int b = 0; b < 4; b++) ex[(base + 4*i + b) % MB] = c[8*b +: 8];
        else ex[(base + i) % MB] = c[8*(i % 4) +: 8];
      end
    end
  endfunction

  function automatic int beats_on(logic [31:0] m, bit deep);
    int n = 0;
    for (int i = 0; i < 32; i++)
      if (deep) n += int'(m[i]);
      else if (i % 4 == 0 && m[i +: 4] != 0) n++;
    return n;
  endfunction

  task automatic cmp_mem(string req);
    int bad = -1;
    for (int i = 0; i < MB; i++) if (sh[i] !== ex[i] && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: byte %0d actual %0h expected %0h", req, bad, sh[bad], ex[bad]);
    end
  endtask

  initial begin
    logic [31:0] lf;
    logic [31:0] fgv, bgv;
    for (int i = 0; i < MB; i++) begin sh[i] = 8'h00; ex[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 stall", host_stall, 0);
    chk("R1 mem_we", mem_we, 0);

    // R2 plain mode (reset mode), one write timed
    @(negedge clk);
    fb_we = 1'b1; fb_addr = 12'h103; fb_wdata = 32'hDEADBEEF;
    @(negedge clk);
    fb_we = 1'b0;
    chk("R2 we", mem_we, 1);
    chk("R2 addr", mem_addr, 12'h100);
    chk("R2 data", mem_wdata, 32'hDEADBEEF);
    chk("R2 be", mem_be, 4'hF);
    for (int b = 0; b < 4; b++) ex[12'h100 + b] = 8'(32'hDEADBEEF >> (8*b));
    @(negedge clk);
    chk("R2 single pulse", mem_we, 0);
    // R2 fill the whole buffer with a pattern to expose untouched bytes
    for (int w = 0; w < MB/4; w++) begin
      logic [31:0] v = 32'h9E3779B9 * (w + 1);
      fb_write(AW'(4*w), v);
      for (int b = 0; b < 4; b++) ex[4*w + b] = v[8*b +: 8];
    end
    settle();
    cmp_mem("R2 fill");

    // R1 pixel mask resets to all ones; R10 encoding of mode and colours
    fgv = 32'h44332211; bgv = 32'h88776655;
    reg_write(2'd0, fgv);
    reg_write(2'd1, bgv);
    reg_write(2'd3, 32'h1);
    we_cnt = 0; busy_cnt = 0;
    fb_write(12'h000, 32'h0000_0001);
    model(12'h000, 32'h1, 32'hFFFF_FFFF, 0, fgv, bgv);
    settle();
    chk("R1 reset pmask beats", we_cnt, 8);
    chk("R8 busy span 8bpp", busy_cnt, 8);
    cmp_mem("R3 R4 R10 bit0 leftmost");

    // Sweep both depths over data, mask and address patterns
    lf = 32'h1ACE_B00C;
    for (int deep = 0; deep < 2; deep++) begin
      reg_write(2'd3, deep ? 32'h3 : 32'h1);
      for (int k = 0; k < 12; k++) begin
        logic [31:0] d, m;
        logic [AW-1:0] a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        case (k)
          0: begin d = 32'h8000_0000; m = 32'hFFFF_FFFF; end
          1: begin d = 32'hFFFF_FFFF; m = 32'hFFFF_FFFF; end
          2: begin d = 32'h0000_0000; m = 32'hFFFF_FFFF; end
          3: begin d = 32'hA5C3_0F96; m = 32'h0000_0000; end
          4: begin d = 32'hA5C3_0F96; m = 32'h0000_FFFF; end
          5: begin d = 32'h5A5A_5A5A; m = 32'h55AA_00FF; end
          6: begin d = 32'h1234_5678; m = 32'hF000_000F; end
          default: begin d = lf; m = lf ^ 32'h3C3C_C3C3; end
        endcase
        fgv = 32'h10203040 + 32'(k); bgv = ~fgv;
        reg_write(2'd0, fgv);
        reg_write(2'd1, bgv);
        reg_write(2'd2, m);
        a = AW'(256 + k*128 + (k % 4));
        we_cnt = 0; busy_cnt = 0;
        fb_write(a, d);
        model(a, d, m, deep[0], fgv, bgv);
        settle();
        chk(deep ? "R5 R8 busy span" : "R4 R8 busy span", busy_cnt, deep ? 32 : 8);
        chk("R6 beat count", we_cnt, beats_on(m, deep[0]));
        cmp_mem(deep ? "R3 R5 R6 R7 memory" : "R3 R4 R6 R7 memory");
      end
    end

    // R9 stall: data write and register write held during expansion
    reg_write(2'd3, 32'h1);
    reg_write(2'd2, 32'hFFFF_FFFF);
    fgv = 32'hCAFEF00D; bgv = 32'h01020304;
    reg_write(2'd0, fgv);
    reg_write(2'd1, bgv);
    stall_seen = 1'b0;
    fb_write(12'hE00, 32'h0F0F_3355);
    reg_write(2'd0, 32'h77777777);
    model(12'hE00, 32'h0F0F_3355, 32'hFFFF_FFFF, 0, fgv, bgv);
    chk("R9 reg write stalled", stall_seen, 1);
    stall_seen = 1'b0;
    fb_write(12'hE40, 32'hFFFF_0000);
    fb_write(12'hE80, 32'h0000_FFFF);
    model(12'hE40, 32'hFFFF_0000, 32'hFFFF_FFFF, 0, 32'h77777777, bgv);
    model(12'hE80, 32'h0000_FFFF, 32'hFFFF_FFFF, 0, 32'h77777777, bgv);
    settle();
    chk("R9 data write stalled", stall_seen, 1);
    cmp_mem("R9 held writes applied");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule